// File: doc/BRIEF.md
# Three-Digit Pushbutton Combination Lock

This block is the sequencing core of a keypad lock. It watches four key lines that are already debounced and synchronous to the system clock (50 MHz in the target system). Key line n enters the digit n. Every low-to-high change on a key line is one keystroke. After exactly three keystrokes the block gives a verdict. One output bit reports that the entered digits match the stored secret (3, then 1, then 0 by default). The other bit reports that they do not.

A wrong digit does not cut the entry short. The machine moves onto a separate failing path and still waits for the full number of keystrokes before it reports the error. So an observer cannot learn which digit was wrong. Both verdict bits stay low while a code is being keyed. A verdict is held until the next keystroke, and that keystroke is taken as the first digit of a fresh attempt. A synchronous active-low clear returns the block to idle. A debug port exposes the phase and the number of digits taken.

Top module: `code_lock`

## Requirements
- R1: Key line n (n = 0..3) enters digit n. A keystroke is registered at the first rising clock edge at which a key line is high after being low at the previous edge. Holding a key counts once. A key that rises while another is held is taken on its own.
- R2: No verdict appears before the third keystroke of an attempt. After the first and second keystrokes `result` is 2'b00.
- R3: The keystrokes 3, 1, 0 in that order set `result` to 2'b01 (bit 0 = open) at the edge that takes the third keystroke.
- R4: Any other three-keystroke sequence sets `result` to 2'b10 (bit 1 = wrong) at the third keystroke, even when the first digit was already wrong.
- R5: Two or more key lines rising at the same edge count as one keystroke carrying a wrong digit.
- R6: A verdict holds with no keystroke. The next keystroke clears it and is taken as digit one of a new attempt.
- R7: While `clr_n` is low at a rising edge, the block returns to idle, with `result` = 2'b00 and `state_dbg` = 0. A key held through the clear does not count as a keystroke after release of the clear.
- R8: The fields of `state_dbg` are as follows. Bits [4:2] give the phase: 0 idle, 1 all digits matching so far, 2 a digit has missed, 3 open verdict, 4 wrong verdict. Bits [1:0] give the digits taken in the current attempt, which is 0 in idle and in both verdict phases. `result` never has both bits set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| clr_n | input | 1 | Synchronous clear, active low |
| key_in | input | 4 | Debounced key lines, bit n enters digit n |
| result | output | 2 | Bit 0 open verdict, bit 1 wrong-code verdict |
| state_dbg | output | 5 | Phase in [4:2], digits taken in [1:0] |

## Verification
The assertions assume that the key lines are clean, with no bounce, and change only between clock edges. They also assume that the clear is the only reset, so every check is suspended while `clr_n` is low. The bench drives keys only at falling clock edges and releases them between keystrokes. It holds keys across several cycles only where the hold or overlap behaviour is under test. It sweeps all 64 single-key three-digit sequences and adds simultaneous-key, held-key and mid-entry clear cases.

// File: rtl/lock_pkg.sv
package lock_pkg;

    localparam int PHASE_W = 3;
    localparam int RES_OPEN  = 0;
    localparam int RES_WRONG = 1;

    typedef enum logic [PHASE_W-1:0] {
        PH_IDLE  = 3'd0,
        PH_MATCH = 3'd1,
        PH_MISS  = 3'd2,
        PH_OPEN  = 3'd3,
        PH_WRONG = 3'd4
    } phase_e;

    function automatic logic is_rest(input phase_e p);
        return (p == PH_IDLE) || (p == PH_OPEN) || (p == PH_WRONG);
    endfunction

endpackage

// File: rtl/lock_key_edge.sv
module lock_key_edge #(
    parameter int NUM_KEYS = 4
) (
    input  logic                clk,
    input  logic                clr_n,
    input  logic [NUM_KEYS-1:0] key_in,
    output logic [NUM_KEYS-1:0] press
);
    logic [NUM_KEYS-1:0] key_q;

    for (genvar i = 0; i < NUM_KEYS; i++) begin : g_key
        // tracks the line even during clear, so a held key is not a press afterwards
        always_ff @(posedge clk) begin
            key_q[i] <= key_in[i];
        end
        assign press[i] = clr_n & key_in[i] & ~key_q[i];
    end
endmodule

// File: rtl/lock_key_decode.sv
module lock_key_decode #(
    parameter int NUM_KEYS = 4,
    parameter int DIGIT_W  = 2
) (
    input  logic [NUM_KEYS-1:0] press,
    output logic                any_press,
    output logic                single,
    output logic [DIGIT_W-1:0]  digit
);
    localparam int CNT_W = $clog2(NUM_KEYS + 1);

    logic [CNT_W-1:0] hits;

    always_comb begin
        hits  = '0;
        digit = '0;
        for (int i = 0; i < NUM_KEYS; i++) begin
            if (press[i]) begin
                hits  = hits + 1'b1;
                digit = digit | DIGIT_W'(i);
            end
        end
        any_press = (hits != '0);
        single    = (hits == CNT_W'(1));
    end
endmodule

// File: rtl/lock_seq_fsm.sv
module lock_seq_fsm
    import lock_pkg::*;
#(
    parameter int                          CODE_LEN = 3,
    parameter int                          DIGIT_W  = 2,
    parameter logic [CODE_LEN*DIGIT_W-1:0] SECRET   = 6'b00_01_11,
    localparam int                         CW       = $clog2(CODE_LEN + 1)
) (
    input  logic               clk,
    input  logic               clr_n,
    input  logic               any_press,
    input  logic               single,
    input  logic [DIGIT_W-1:0] digit,
    output phase_e             phase,
    output logic [CW-1:0]      taken
);
    localparam logic [CW-1:0] LAST = CW'(CODE_LEN);

    phase_e          phase_n;
    logic [CW-1:0]   taken_n;
    logic [CW-1:0]   base;
    logic [CW-1:0]   step;
    logic            ok_so_far;
    logic            hit;

    function automatic logic [DIGIT_W-1:0] want(input logic [CW-1:0] idx);
        logic [DIGIT_W-1:0] d;
        d = '0;
        for (int k = 0; k < CODE_LEN; k++) begin
            if (idx == CW'(k)) d = SECRET[k*DIGIT_W +: DIGIT_W];
        end
        return d;
    endfunction

    always_comb begin
        base      = is_rest(phase) ? '0 : taken;
        ok_so_far = (phase != PH_MISS);
        hit       = single && (digit == want(base));
        step      = base + 1'b1;
        phase_n   = phase;
        taken_n   = taken;
        if (any_press) begin
            if (step == LAST) begin
                phase_n = (ok_so_far && hit) ? PH_OPEN : PH_WRONG;
                taken_n = '0;
            end else begin
                phase_n = (ok_so_far && hit) ? PH_MATCH : PH_MISS;
                taken_n = step;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!clr_n) begin
            phase <= PH_IDLE;
            taken <= '0;
        end else begin
            phase <= phase_n;
            taken <= taken_n;
        end
    end
endmodule

// File: rtl/code_lock.sv
module code_lock
    import lock_pkg::*;
#(
    parameter int                                        NUM_KEYS = 4,
    parameter int                                        CODE_LEN = 3,
    parameter logic [CODE_LEN*$clog2(NUM_KEYS)-1:0]      SECRET   = 6'b00_01_11,
    localparam int                                       DIGIT_W  = $clog2(NUM_KEYS),
    localparam int                                       CW       = $clog2(CODE_LEN + 1)
) (
    input  logic                    clk,
    input  logic                    clr_n,
    input  logic [NUM_KEYS-1:0]     key_in,
    output logic [1:0]              result,
    output logic [PHASE_W+CW-1:0]   state_dbg
);
    logic [NUM_KEYS-1:0] press_vec;
    logic                any_press;
    logic                single;
    logic [DIGIT_W-1:0]  digit;
    phase_e              phase;
    logic [CW-1:0]       taken;

    lock_key_edge #(.NUM_KEYS(NUM_KEYS)) i_edge (
        .clk    (clk),
        .clr_n  (clr_n),
        .key_in (key_in),
        .press  (press_vec)
    );

    lock_key_decode #(.NUM_KEYS(NUM_KEYS), .DIGIT_W(DIGIT_W)) i_decode (
        .press     (press_vec),
        .any_press (any_press),
        .single    (single),
        .digit     (digit)
    );

    lock_seq_fsm #(.CODE_LEN(CODE_LEN), .DIGIT_W(DIGIT_W), .SECRET(SECRET)) i_fsm (
        .clk       (clk),
        .clr_n     (clr_n),
        .any_press (any_press),
        .single    (single),
        .digit     (digit),
        .phase     (phase),
        .taken     (taken)
    );

    always_comb begin
        result            = '0;
        result[RES_OPEN]  = (phase == PH_OPEN);
        result[RES_WRONG] = (phase == PH_WRONG);
        state_dbg         = {phase, taken};
    end
endmodule

// File: rtl/code_lock_chk.sv
module code_lock_chk #(
    parameter int NUM_KEYS = 4,
    parameter int CODE_LEN = 3,
    localparam int CW = $clog2(CODE_LEN + 1)
) (
    input logic                clk,
    input logic                clr_n,
    input logic [NUM_KEYS-1:0] key_in,
    input logic [NUM_KEYS-1:0] press_vec,
    input logic [1:0]          result,
    input logic [3+CW-1:0]     state_dbg
);
    logic [2:0]    mode;
    logic [CW-1:0] cnt;
    assign mode = state_dbg[3+CW-1:CW];
    assign cnt  = state_dbg[CW-1:0];

    // R8: verdict bits exclusive
    p_verdict_onehot_r8: assert property (@(posedge clk) disable iff (!clr_n)
        $onehot0(result));

    // R2: outputs dark while digits are being taken
    p_dark_entry_r2: assert property (@(posedge clk) disable iff (!clr_n)
        (cnt != '0) |-> (result == 2'b00));

    // R1: nothing moves without a keystroke
    p_idle_stable_r1: assert property (@(posedge clk) disable iff (!clr_n)
        (press_vec == '0) |=> $stable(state_dbg));

    // R1: a keystroke only from a line that was low and is now high
    p_edge_only_r1: assert property (@(posedge clk) disable iff (!clr_n)
        (press_vec != '0) |-> (((press_vec & ~key_in) == '0) && ((press_vec & $past(key_in)) == '0)));

    // R5: simultaneous keys never leave a matching path or open
    p_multi_wrong_r5: assert property (@(posedge clk) disable iff (!clr_n)
        ($countones(press_vec) > 1) |=> (!result[0] && mode != 3'd1));

    // R6: any keystroke leaves the rest phase behind
    p_press_moves_r6: assert property (@(posedge clk) disable iff (!clr_n)
        (press_vec != '0) |=> ((cnt != '0) || (result != 2'b00)));
endmodule

bind code_lock code_lock_chk #(.NUM_KEYS(NUM_KEYS), .CODE_LEN(CODE_LEN)) i_chk (
    .clk       (clk),
    .clr_n     (clr_n),
    .key_in    (key_in),
    .press_vec (press_vec),
    .result    (result),
    .state_dbg (state_dbg)
);

// File: tb/test_code_lock.sv
module test_code_lock;
    localparam int CLK_PERIOD = 20;

    logic       clk = 1'b0;
    logic       clr_n = 1'b0;
    logic [3:0] key_in = 4'b0000;
    logic [1:0] result;
    logic [4:0] state_dbg;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    code_lock i_code_lock (
        .clk       (clk),
        .clr_n     (clr_n),
        .key_in    (key_in),
        .result    (result),
        .state_dbg (state_dbg)
    );

    function automatic logic [4:0] dbg(input int mode, input int cnt);
        return {3'(mode), 2'(cnt)};
    endfunction

    task automatic expect_out(input string tag, input logic [1:0] er, input logic [4:0] ed);
        checks++;
        if (result !== er || state_dbg !== ed) begin
            errors++;
            $display("FAIL %s result=%b exp=%b state=%b exp=%b", tag, result, er, state_dbg, ed);
        end
    endtask

    // drive a key pattern for one edge, release at the following falling edge
    task automatic press(input logic [3:0] keys);
        @(negedge clk);
        key_in = keys;
        @(negedge clk);
        key_in = 4'b0000;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle(3);
        expect_out("R7 reset idle", 2'b00, dbg(0, 0));
        clr_n = 1'b1;
        idle(2);
        expect_out("R7 after clear release", 2'b00, dbg(0, 0));

        // exhaustive single-key sweep, R1 R2 R3 R4
        for (int a = 0; a < 4; a++) begin
            for (int b = 0; b < 4; b++) begin
                for (int c = 0; c < 4; c++) begin
                    logic ok1, ok2, ok3;
                    ok1 = (a == 3);
                    ok2 = ok1 && (b == 1);
                    ok3 = ok2 && (c == 0);
                    press(4'(1 << a));
                    expect_out("R1 R2 first digit", 2'b00, dbg(ok1 ? 1 : 2, 1));
                    press(4'(1 << b));
                    expect_out("R2 second digit", 2'b00, dbg(ok2 ? 1 : 2, 2));
                    press(4'(1 << c));
                    if (ok3) expect_out("R3 open", 2'b01, dbg(3, 0));
                    else     expect_out("R4 wrong", 2'b10, dbg(4, 0));
                    idle(2);
                    expect_out("R6 verdict held", ok3 ? 2'b01 : 2'b10, dbg(ok3 ? 3 : 4, 0));
                end
            end
        end

        // R6: long hold of open verdict, then next press restarts
        press(4'b1000); press(4'b0010); press(4'b0001);
        idle(10);
        expect_out("R6 open held long", 2'b01, dbg(3, 0));
        press(4'b1000);
        expect_out("R6 press restarts entry", 2'b00, dbg(1, 1));

        // R1: holding key counts once
        @(negedge clk);
        key_in = 4'b0010;
        idle(6);
        expect_out("R1 held key single press", 2'b00, dbg(1, 2));
        // R1: second key rising while first held is its own press
        key_in = 4'b0011;
        idle(1);
        expect_out("R1 overlap key taken", 2'b01, dbg(3, 0));
        key_in = 4'b0000;
        idle(2);

        // R5: simultaneous keys as first digit
        press(4'b1010);
        expect_out("R5 multi first", 2'b00, dbg(2, 1));
        press(4'b0010); press(4'b0001);
        expect_out("R5 multi gives wrong", 2'b10, dbg(4, 0));
        // R5: simultaneous keys as second digit
        press(4'b1000); press(4'b0011);
        expect_out("R5 multi second", 2'b00, dbg(2, 2));
        press(4'b0001);
        expect_out("R5 multi second wrong", 2'b10, dbg(4, 0));

        // R7: clear mid entry
        press(4'b1000); press(4'b0010);
        @(negedge clk);
        clr_n = 1'b0;
        idle(1);
        expect_out("R7 clear mid entry", 2'b00, dbg(0, 0));
        clr_n = 1'b1;
        press(4'b0001);
        expect_out("R7 fresh start after clear", 2'b00, dbg(2, 1));
        press(4'b0001); press(4'b0001);
        expect_out("R4 after clear", 2'b10, dbg(4, 0));

        // R7: key held through clear is not a press
        press(4'b1000); press(4'b0010); press(4'b0001);
        @(negedge clk);
        key_in = 4'b1000;
        clr_n = 1'b0;
        idle(2);
        expect_out("R7 clear ends verdict", 2'b00, dbg(0, 0));
        clr_n = 1'b1;
        idle(3);
        expect_out("R7 held key ignored after clear", 2'b00, dbg(0, 0));
        key_in = 4'b0000;
        idle(1);
        press(4'b1000); press(4'b0010); press(4'b0001);
        expect_out("R3 open after clear", 2'b01, dbg(3, 0));

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule